// File: doc/BRIEF.md
# Self-Heating Cancellation Calculator

A ring modulator absorbs part of the laser light that resonates in it, and how much it absorbs depends on whether it is sending ones or zeros. When the density of ones in the data drifts, the ring heats or cools on its own and moves off its lock point. This block computes a feed-forward heater correction for every N-bit interval. The correction is proportional to the gain K, to the fraction of ones N1/N seen in the interval, and to the eye height I1 − I0 reported by the level solver. The lock controller supplies a base heater code, and the block adds the correction to it, saturating the sum at the full-scale DAC code.

The ones count comes from the parallel transmit words ahead of the serializer. An interval is 2^WORDS_LOG2 valid words, so N = DATA_W · 2^WORDS_LOG2 bits. A control state machine then runs the arithmetic over four named states. ST_COLLECT waits for the end of an interval; on that event (transition "interval end") it captures N1 and the clamped level difference. ST_PRODUCT forms difference × N1 ("product done"). ST_GAIN multiplies that product by K ("gain done"). ST_SCALE divides by N · 2^K_FRAC, saturates the result, stores it, and returns to ST_COLLECT ("store"). An enable input can mask the correction so that tracking with and without cancellation can be compared.

Top module: `shc_cancel_calc`

## Requirements
- R1: While reset (rst_n low) is held, and after it, until the first correction is stored, corr_code is 0 and heater_code equals base_code.
- R2: One interval is 2^WORDS_LOG2 (default 4) words of DATA_W bits (default 8), N = 32 bits. Only words with tx_valid high are counted, and N1 is the number of 1 bits they carry.
- R3: The stored correction is floor(K · N1 · D / (N · 2^K_FRAC)). K is gain_k, an unsigned fixed-point value with K_FRAC (default 4) fraction bits. D = level_one − level_zero.
- R4: When level_one ≤ level_zero, D is taken as 0 and the correction is 0.
- R5: A correction larger than 2^DAC_W − 1 (default 1023) is stored as 2^DAC_W − 1.
- R6: heater_code = min(base_code + corr_code, 2^DAC_W − 1).
- R7: While cancel_en is low, corr_code is 0 and heater_code equals base_code in the same cycle. The stored correction is kept and shows again when cancel_en returns high.
- R8: A new correction shows on corr_code 4 clock cycles after the edge that accepts the last word of an interval, and holds at all other times. The levels must be held from that edge through the next one. gain_k must be held for the next 3 edges.
- R9: The state machine leaves ST_COLLECT only on an interval end, then visits ST_PRODUCT, ST_GAIN and ST_SCALE for one cycle each and returns to ST_COLLECT. WORDS_LOG2 must be at least 2 so that an interval never ends while the arithmetic is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | tx_word holds a transmit word |
| tx_word | input | DATA_W | Parallel transmit word ahead of the serializer |
| level_one | input | LVL_W | Solved 1-level (I1) |
| level_zero | input | LVL_W | Solved 0-level (I0) |
| gain_k | input | K_W | Cancellation gain, unsigned, K_FRAC fraction bits |
| cancel_en | input | 1 | High to apply the correction |
| base_code | input | DAC_W | Base heater code from the lock controller |
| corr_code | output | DAC_W | Applied cancellation code |
| heater_code | output | DAC_W | Saturated base plus correction |

## Verification
The assertions on the state sequence and on the hold of the stored correction assume that intervals are at least four words long, so that the end of one interval never falls while the arithmetic is running. The bench always sends complete intervals of four or more cycles and then waits for the store before it starts the next one. The bench keeps the levels and the gain steady from the first word of an interval until the correction is checked, so each captured value is the one it intended. Base code and enable may change at any time, because the output checks relate them combinationally.

// File: rtl/shc_pkg.sv
package shc_pkg;
    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_PRODUCT,
        ST_GAIN,
        ST_SCALE
    } calc_state_t;
endpackage

// File: rtl/shc_ones_counter.sv
// Counts one bits across an interval of 2**WORDS_LOG2 valid words.
module shc_ones_counter #(
    parameter int DATA_W     = 8,
    parameter int WORDS_LOG2 = 2,
    localparam int WORDS     = 1 << WORDS_LOG2,
    localparam int CNT_W     = $clog2(DATA_W * WORDS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word,
    output logic [CNT_W-1:0]  ones_total,
    output logic              interval_done
);
    localparam logic [WORDS_LOG2-1:0] LAST_IDX = WORDS_LOG2'(WORDS - 1);

    logic [CNT_W-1:0]      pop;
    logic [CNT_W-1:0]      acc;
    logic [WORDS_LOG2-1:0] widx;

    always_comb begin
        pop = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pop = pop + CNT_W'(word[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc           <= '0;
            widx          <= '0;
            ones_total    <= '0;
            interval_done <= 1'b0;
        end else begin
            interval_done <= 1'b0;
            if (word_valid) begin
                if (widx == LAST_IDX) begin
                    ones_total    <= acc + pop;
                    acc           <= '0;
                    widx          <= '0;
                    interval_done <= 1'b1;
                end else begin
                    acc  <= acc + pop;
                    widx <= widx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/shc_sat_add.sv
// Adds two DAC codes and clips the sum at full scale.
module shc_sat_add #(
    parameter int DAC_W = 10
) (
    input  logic [DAC_W-1:0] base,
    input  logic [DAC_W-1:0] corr,
    output logic [DAC_W-1:0] sum
);
    logic [DAC_W:0] wide;

    always_comb begin
        wide = {1'b0, base} + {1'b0, corr};
        sum  = wide[DAC_W] ? {DAC_W{1'b1}} : wide[DAC_W-1:0];
    end
endmodule

// File: rtl/shc_cancel_calc.sv
// Feed-forward self-heating cancellation: K * (N1/N) * max(I1 - I0, 0).
module shc_cancel_calc
    import shc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int WORDS_LOG2 = 2,
    parameter int LVL_W      = 12,
    parameter int K_W        = 8,
    parameter int K_FRAC     = 4,
    parameter int DAC_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [LVL_W-1:0]  level_one,
    input  logic [LVL_W-1:0]  level_zero,
    input  logic [K_W-1:0]    gain_k,
    input  logic              cancel_en,
    input  logic [DAC_W-1:0]  base_code,
    output logic [DAC_W-1:0]  corr_code,
    output logic [DAC_W-1:0]  heater_code
);
    localparam int N_LOG2 = $clog2(DATA_W) + WORDS_LOG2;
    localparam int CNT_W  = N_LOG2 + 1;
    localparam int P1_W   = LVL_W + CNT_W;
    localparam int P2_W   = P1_W + K_W;
    localparam int SHIFT  = N_LOG2 + K_FRAC;

    calc_state_t      state, state_nx;
    logic [CNT_W-1:0] ones_w;
    logic             done;
    logic [CNT_W-1:0] n1_q;
    logic [LVL_W-1:0] diff_q;
    logic [P2_W-1:0]  prod_q;
    logic [DAC_W-1:0] corr_q;
    logic [LVL_W:0]   diff_raw;
    logic [LVL_W-1:0] diff_clamped;
    logic [P2_W-1:0]  scaled;
    logic [DAC_W-1:0] corr_nx;

    shc_ones_counter #(
        .DATA_W    (DATA_W),
        .WORDS_LOG2(WORDS_LOG2)
    ) i_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_valid   (tx_valid),
        .word         (tx_word),
        .ones_total   (ones_w),
        .interval_done(done)
    );

    // Level difference, clamped at zero when the ones level is not above
    always_comb begin
        diff_raw     = {1'b0, level_one} - {1'b0, level_zero};
        diff_clamped = diff_raw[LVL_W] ? '0 : diff_raw[LVL_W-1:0];
    end

    // Divide by N * 2**K_FRAC, saturate to the DAC range
    always_comb begin
        scaled  = prod_q >> SHIFT;
        corr_nx = (|scaled[P2_W-1:DAC_W]) ? {DAC_W{1'b1}} : scaled[DAC_W-1:0];
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COLLECT: if (done) state_nx = ST_PRODUCT;
            ST_PRODUCT: state_nx = ST_GAIN;
            ST_GAIN:    state_nx = ST_SCALE;
            ST_SCALE:   state_nx = ST_COLLECT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_COLLECT;
        else        state <= state_nx;
    end

    // Datapath registers driven by state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n1_q   <= '0;
            diff_q <= '0;
            prod_q <= '0;
            corr_q <= '0;
        end else begin
            unique case (state)
                ST_COLLECT: begin
                    if (done) begin
                        n1_q   <= ones_w;
                        diff_q <= diff_clamped;
                    end
                end
                ST_PRODUCT: prod_q <= P2_W'(diff_q) * P2_W'(n1_q);
                ST_GAIN:    prod_q <= prod_q * P2_W'(gain_k);
                ST_SCALE:   corr_q <= corr_nx;
            endcase
        end
    end

    assign corr_code = cancel_en ? corr_q : '0;

    shc_sat_add #(
        .DAC_W(DAC_W)
    ) i_sum (
        .base(base_code),
        .corr(corr_code),
        .sum (heater_code)
    );
endmodule

// File: rtl/shc_cancel_chk.sv
module shc_cancel_chk
    import shc_pkg::*;
#(
    parameter int DAC_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cancel_en,
    input logic             done,
    input calc_state_t      state,
    input logic [DAC_W-1:0] corr_q,
    input logic [DAC_W-1:0] base_code,
    input logic [DAC_W-1:0] corr_code,
    input logic [DAC_W-1:0] heater_code
);
    localparam logic [DAC_W:0] FULL = {1'b0, {DAC_W{1'b1}}};

    p_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COLLECT && !done) |=> state == ST_COLLECT);
    p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COLLECT && done) |=> state == ST_PRODUCT);
    p_product_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRODUCT) |=> state == ST_GAIN);
    p_gain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAIN) |=> state == ST_SCALE);
    p_scale_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCALE) |=> state == ST_COLLECT);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SCALE) |=> $stable(corr_q));
    p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cancel_en |-> (corr_code == '0 && heater_code == base_code));
    p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        heater_code >= base_code);
    p_clip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (({1'b0, base_code} + {1'b0, corr_code}) > FULL) |-> heater_code == FULL[DAC_W-1:0]);
endmodule

bind shc_cancel_calc shc_cancel_chk #(.DAC_W(DAC_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cancel_en  (cancel_en),
    .done       (done),
    .state      (state),
    .corr_q     (corr_q),
    .base_code  (base_code),
    .corr_code  (corr_code),
    .heater_code(heater_code)
);

// File: tb/test_shc_cancel_calc.sv
module test_shc_cancel_calc;
    typedef struct packed {
        logic [7:0]  b;
        logic [11:0] l1;
        logic [11:0] l0;
        logic [7:0]  k;
        logic [9:0]  base;
        logic [9:0]  corr;
        logic [9:0]  heat;
    } vec_t;

    // One byte repeated over the four words of an interval
    localparam vec_t VECS [10] = '{
        '{8'hFF, 12'd1000, 12'd200, 8'd16,  10'd300,  10'd800,  10'd1023}, // R3 R6 clip
        '{8'h0F, 12'd1000, 12'd200, 8'd16,  10'd300,  10'd400,  10'd700},  // R3 half density
        '{8'h00, 12'd1000, 12'd200, 8'd16,  10'd300,  10'd0,    10'd300},  // R2 no ones
        '{8'h01, 12'd1000, 12'd200, 8'd16,  10'd500,  10'd100,  10'd600},  // R3 sparse ones
        '{8'hFF, 12'd100,  12'd900, 8'd16,  10'd500,  10'd0,    10'd500},  // R4 negative
        '{8'h55, 12'd1000, 12'd200, 8'd8,   10'd0,    10'd200,  10'd200},  // R3 gain 0.5
        '{8'hFF, 12'd4095, 12'd0,   8'd255, 10'd0,    10'd1023, 10'd1023}, // R5 saturate
        '{8'hFF, 12'd10,   12'd7,   8'd16,  10'd1021, 10'd3,    10'd1023}, // R6 sum clip
        '{8'h80, 12'd1,    12'd0,   8'd16,  10'd10,   10'd0,    10'd10},   // R3 floor
        '{8'hFF, 12'd500,  12'd500, 8'd16,  10'd42,   10'd0,    10'd42}    // R4 equal
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_valid;
    logic [7:0]  tx_word;
    logic [11:0] level_one;
    logic [11:0] level_zero;
    logic [7:0]  gain_k;
    logic        cancel_en;
    logic [9:0]  base_code;
    logic [9:0]  corr_code;
    logic [9:0]  heater_code;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    shc_cancel_calc i_shc_cancel_calc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_valid   (tx_valid),
        .tx_word    (tx_word),
        .level_one  (level_one),
        .level_zero (level_zero),
        .gain_k     (gain_k),
        .cancel_en  (cancel_en),
        .base_code  (base_code),
        .corr_code  (corr_code),
        .heater_code(heater_code)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Sends four valid words; returns at the negedge after the last accepting edge
    task automatic send4(input logic [7:0] w0, input logic [7:0] w1,
                         input logic [7:0] w2, input logic [7:0] w3);
        @(negedge clk); tx_valid = 1'b1; tx_word = w0;
        @(negedge clk); tx_word = w1;
        @(negedge clk); tx_word = w2;
        @(negedge clk); tx_word = w3;
        @(negedge clk); tx_valid = 1'b0; tx_word = 8'h00;
    endtask

    task automatic wait_store();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tx_valid = 1'b0; tx_word = 8'h00;
        level_one = 12'd0; level_zero = 12'd0; gain_k = 8'd16;
        cancel_en = 1'b1; base_code = 10'd123;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 corr in reset", corr_code, 0);
        check("R1 heater in reset", heater_code, 123);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 corr after reset", corr_code, 0);
        check("R1 heater after reset", heater_code, 123);

        foreach (VECS[i]) begin
            level_one = VECS[i].l1; level_zero = VECS[i].l0;
            gain_k = VECS[i].k; base_code = VECS[i].base;
            send4(VECS[i].b, VECS[i].b, VECS[i].b, VECS[i].b);
            wait_store();
            check($sformatf("R3 corr vec %0d", i), corr_code, VECS[i].corr);
            check($sformatf("R6 heater vec %0d", i), heater_code, VECS[i].heat);
        end

        // R2: mixed bytes, cycles without valid are not counted: 8+0+4+1 = 13 ones
        level_one = 12'd1000; level_zero = 12'd200; gain_k = 8'd16; base_code = 10'd100;
        @(negedge clk); tx_valid = 1'b1; tx_word = 8'hFF;
        @(negedge clk); tx_valid = 1'b0; tx_word = 8'hFF;
        @(negedge clk); tx_valid = 1'b1; tx_word = 8'h00;
        @(negedge clk); tx_valid = 1'b0; tx_word = 8'hFF;
        @(negedge clk); tx_valid = 1'b1; tx_word = 8'hF0;
        @(negedge clk); tx_word = 8'h01;
        @(negedge clk); tx_valid = 1'b0; tx_word = 8'h00;
        wait_store();
        check("R2 corr with gaps", corr_code, 325);
        check("R2 heater with gaps", heater_code, 425);

        // R7: masking is immediate and keeps the stored value
        base_code = 10'd300;
        send4(8'h0F, 8'h0F, 8'h0F, 8'h0F);
        wait_store();
        check("R7 corr before mask", corr_code, 400);
        cancel_en = 1'b0;
        #1;
        check("R7 corr masked", corr_code, 0);
        check("R7 heater masked", heater_code, 300);
        @(negedge clk);
        cancel_en = 1'b1;
        #1;
        check("R7 corr restored", corr_code, 400);

        // R8: the value changes exactly on the fourth edge after the last word
        base_code = 10'd0;
        send4(8'hFF, 8'hFF, 8'hFF, 8'hFF);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 corr held before store", corr_code, 400);
        @(negedge clk);
        check("R8 corr after store", corr_code, 800);
        check("R6 heater zero base", heater_code, 800);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule